// File: doc/BRIEF.md
# Ordered Flush and Dispatch Wave Chain

This block is a chain of control-network hop registers that carries commands from a central control tile out to the execution, register and data tiles of a tiled processor core. Two kinds of command use it: a flush, raised when a branch misprediction is found, whose payload is a mask of the in-flight block slots to discard; and a dispatch, whose payload identifies the block being sent out. Each hop is a single register, so a command moves exactly one tile further every clock cycle. Each tile sees the command on its local outputs for exactly one cycle, as the command passes through that tile's hop.

Flushes and dispatches go through the same registers, in the same order. A dispatch that the central tile injects in the cycle right after a flush therefore reaches every tile one cycle after that flush, and never before it. No handshake or arbitration is needed to get this ordering. The payload is 8 bits, one bit per block slot, because up to eight blocks can be in flight.

Top module: `flush_wave_chain`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every `tile_flush`, `tile_dispatch` and `tile_payload` bit is 0. A reset in the middle of traffic discards every command still travelling on the chain.
- R2: A command injected with `inj_valid` high and `inj_kind` = 1 is a flush. When the clock edge samples it, tile 0 raises `tile_flush[0]` in the following cycle, and `tile_payload` for tile 0 equals the injected slot mask.
- R3: Tile index i sits at hop distance i+1. It presents a command during exactly the cycle that starts i+1 clock edges after the edge that sampled the injection, and only for that one cycle.
- R4: A dispatch (`inj_kind` = 0) injected in the cycle after a flush is seen at every tile exactly one cycle after that flush. It never reaches any tile in the same cycle as the flush or earlier.
- R5: The 8-bit payload reaches every tile unchanged. The payload of tile i is `tile_payload[8*i +: 8]`, and it reads 0 when no command is present at that tile.
- R6: When `inj_valid` is low, no command enters the chain. Once earlier traffic has drained, all tile outputs stay 0.
- R7: Commands injected on consecutive cycles are all delivered. Each keeps its own payload and kind, and they sit at adjacent tiles in injection order.
- R8: At any tile, at most one of `tile_flush[i]` and `tile_dispatch[i]` is high in a given cycle, and which one is high follows the injected kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_valid | input | 1 | Central tile injects a command this cycle |
| inj_kind | input | 1 | 1 = flush, 0 = dispatch |
| inj_payload | input | 8 | Block-slot mask (flush) or block identifier (dispatch) |
| tile_flush | output | N_HOPS | One-cycle flush strobe per tile |
| tile_dispatch | output | N_HOPS | One-cycle dispatch strobe per tile |
| tile_payload | output | 8*N_HOPS | Payload per tile, 0 when idle |

## Verification
A single flush is followed tile by tile, which separates a wrong hop delay from a wrong payload or a pulse that lasts too long. A flush followed at once by a dispatch shows whether the dispatch ever catches up with the flush, or lands on the same tile as it. A burst of mixed commands on consecutive cycles exposes any dropped, merged or reordered commands. Idle stretches and a reset in the middle of traffic show whether commands appear on their own or survive a reset.

// File: rtl/fwn_pkg.sv
package fwn_pkg;

    localparam int BLOCK_SLOTS = 8;

    typedef enum logic {
        CMD_DISPATCH = 1'b0,
        CMD_FLUSH    = 1'b1
    } cmd_kind_e;

    typedef struct packed {
        logic                   vld;
        cmd_kind_e              kind;
        logic [BLOCK_SLOTS-1:0] pay;
    } hop_cmd_t;

endpackage

// File: rtl/fwn_hop.sv
module fwn_hop
    import fwn_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  hop_cmd_t up_cmd,
    output hop_cmd_t cmd_q
);

    typedef struct packed {
        hop_cmd_t cmd;
    } hop_state_t;

    hop_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cmd = up_cmd;
        if (!up_cmd.vld) begin
            st_d.cmd.kind = CMD_DISPATCH;
            st_d.cmd.pay  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_q = st_q.cmd;

endmodule

// File: rtl/fwn_tap.sv
module fwn_tap
    import fwn_pkg::*;
(
    input  hop_cmd_t               cmd,
    output logic                   flush_o,
    output logic                   dispatch_o,
    output logic [BLOCK_SLOTS-1:0] payload_o
);

    always_comb begin
        flush_o    = cmd.vld && (cmd.kind == CMD_FLUSH);
        dispatch_o = cmd.vld && (cmd.kind == CMD_DISPATCH);
        payload_o  = cmd.vld ? cmd.pay : '0;
    end

endmodule

// File: rtl/flush_wave_chain.sv
module flush_wave_chain
    import fwn_pkg::*;
#(
    parameter int N_HOPS = 6,
    localparam int PW    = BLOCK_SLOTS
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inj_valid,
    input  logic                 inj_kind,
    input  logic [PW-1:0]        inj_payload,
    output logic [N_HOPS-1:0]    tile_flush,
    output logic [N_HOPS-1:0]    tile_dispatch,
    output logic [N_HOPS*PW-1:0] tile_payload
);

    hop_cmd_t inj_cmd;
    hop_cmd_t chain [N_HOPS];

    always_comb begin
        inj_cmd.vld  = inj_valid;
        inj_cmd.kind = inj_kind ? CMD_FLUSH : CMD_DISPATCH;
        inj_cmd.pay  = inj_payload;
    end

    for (genvar i = 0; i < N_HOPS; i++) begin : g_hop
        hop_cmd_t upstream;
        if (i == 0) begin : g_first
            assign upstream = inj_cmd;
        end else begin : g_next
            assign upstream = chain[i-1];
        end

        fwn_hop u_hop (
            .clk    (clk),
            .rst_n  (rst_n),
            .up_cmd (upstream),
            .cmd_q  (chain[i])
        );

        fwn_tap u_tap (
            .cmd        (chain[i]),
            .flush_o    (tile_flush[i]),
            .dispatch_o (tile_dispatch[i]),
            .payload_o  (tile_payload[i*PW +: PW])
        );
    end

endmodule

// File: rtl/flush_wave_chain_chk.sv
module flush_wave_chain_chk #(
    parameter int N_HOPS = 6,
    parameter int PW     = 8
)(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 inj_valid,
    input logic                 inj_kind,
    input logic [PW-1:0]        inj_payload,
    input logic [N_HOPS-1:0]    tile_flush,
    input logic [N_HOPS-1:0]    tile_dispatch,
    input logic [N_HOPS*PW-1:0] tile_payload
);

    p_inject_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && inj_kind) |=> (tile_flush[0] && !tile_dispatch[0]
            && tile_payload[PW-1:0] == $past(inj_payload)));

    p_inject_disp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && !inj_kind) |=> (tile_dispatch[0] && !tile_flush[0]
            && tile_payload[PW-1:0] == $past(inj_payload)));

    p_idle_inject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_valid |=> (!tile_flush[0] && !tile_dispatch[0] && tile_payload[PW-1:0] == '0));

    for (genvar i = 0; i < N_HOPS; i++) begin : g_tile
        p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(tile_flush[i] && tile_dispatch[i]));

        if (i + 1 < N_HOPS) begin : g_adv
            p_flush_hop_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tile_flush[i] |=> (tile_flush[i+1]
                    && tile_payload[(i+1)*PW +: PW] == $past(tile_payload[i*PW +: PW])));

            p_disp_hop_r7: assert property (@(posedge clk) disable iff (!rst_n)
                tile_dispatch[i] |=> (tile_dispatch[i+1]
                    && tile_payload[(i+1)*PW +: PW] == $past(tile_payload[i*PW +: PW])));

            p_no_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !(tile_flush[i] || tile_dispatch[i]) |=>
                    (!tile_flush[i+1] && !tile_dispatch[i+1]));
        end
    end

endmodule

bind flush_wave_chain flush_wave_chain_chk #(.N_HOPS(N_HOPS), .PW(PW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .inj_valid     (inj_valid),
    .inj_kind      (inj_kind),
    .inj_payload   (inj_payload),
    .tile_flush    (tile_flush),
    .tile_dispatch (tile_dispatch),
    .tile_payload  (tile_payload)
);

// File: tb/flush_wave_chain_tb.sv
module flush_wave_chain_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 6;
    localparam int PW         = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              inj_valid = 1'b0;
    logic              inj_kind = 1'b0;
    logic [PW-1:0]     inj_payload = '0;
    logic [N-1:0]      tile_flush;
    logic [N-1:0]      tile_dispatch;
    logic [N*PW-1:0]   tile_payload;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flush_wave_chain #(.N_HOPS(N)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .inj_valid     (inj_valid),
        .inj_kind      (inj_kind),
        .inj_payload   (inj_payload),
        .tile_flush    (tile_flush),
        .tile_dispatch (tile_dispatch),
        .tile_payload  (tile_payload)
    );

    task automatic expect_tile(int idx, logic ef, logic ed, logic [PW-1:0] ep, string req);
        logic [PW-1:0] ap;
        ap = tile_payload[idx*PW +: PW];
        checks++;
        if (tile_flush[idx] !== ef || tile_dispatch[idx] !== ed || ap !== ep) begin
            fails++;
            $display("FAIL %s tile %0d: actual flush=%b disp=%b pay=%h expected flush=%b disp=%b pay=%h",
                     req, idx, tile_flush[idx], tile_dispatch[idx], ap, ef, ed, ep);
        end
    endtask

    task automatic expect_all_idle(string req);
        for (int j = 0; j < N; j++) expect_tile(j, 1'b0, 1'b0, '0, req);
    endtask

    task automatic drive(logic v, logic k, logic [PW-1:0] p);
        inj_valid   = v;
        inj_kind    = k;
        inj_payload = p;
    endtask

    task automatic test_reset;
        expect_all_idle("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_all_idle("R1");
    endtask

    // R2, R3, R5: a single flush walks one tile per cycle
    task automatic test_single_flush;
        @(negedge clk);
        drive(1'b1, 1'b1, 8'hA5);
        @(negedge clk);
        drive(1'b0, 1'b0, '0);
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (j == i) expect_tile(j, 1'b1, 1'b0, 8'hA5, (i == 0) ? "R2" : "R3");
                else        expect_tile(j, 1'b0, 1'b0, '0, "R3");
            end
            @(negedge clk);
        end
        expect_all_idle("R6");
    endtask

    // R4: dispatch right behind a flush stays one tile behind everywhere
    task automatic test_flush_then_dispatch;
        @(negedge clk);
        drive(1'b1, 1'b1, 8'h0F);
        @(negedge clk);
        drive(1'b1, 1'b0, 8'h3C);
        expect_tile(0, 1'b1, 1'b0, 8'h0F, "R4");
        @(negedge clk);
        drive(1'b0, 1'b0, '0);
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (j == i)          expect_tile(j, 1'b0, 1'b1, 8'h3C, "R4");
                else if (j == i + 1) expect_tile(j, 1'b1, 1'b0, 8'h0F, "R4");
                else                 expect_tile(j, 1'b0, 1'b0, '0, "R4");
            end
            @(negedge clk);
        end
    endtask

    // R7, R8, R5: burst of mixed commands on consecutive cycles
    task automatic test_burst;
        logic [PW-1:0] pays [4];
        logic          kinds [4];
        pays  = '{8'h01, 8'h80, 8'hFF, 8'h00};
        kinds = '{1'b1, 1'b0, 1'b1, 1'b0};
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            drive(1'b1, kinds[c], pays[c]);
        end
        @(negedge clk);
        drive(1'b0, 1'b0, '0);
        // last command sits at tile 0, first at tile 3
        for (int c = 0; c < 4; c++)
            expect_tile(3 - c, kinds[c], !kinds[c], pays[c], "R7");
        @(negedge clk);
        @(negedge clk);
        for (int c = 0; c < 4; c++)
            expect_tile(5 - c, kinds[c], !kinds[c], pays[c], "R8");
        expect_tile(0, 1'b0, 1'b0, '0, "R6");
        expect_tile(1, 1'b0, 1'b0, '0, "R6");
        repeat (N) @(negedge clk);
        expect_all_idle("R6");
    endtask

    // R6: payload and kind changes without valid do nothing
    task automatic test_idle_noise;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            drive(1'b0, c[0], 8'h5A ^ 8'(c));
        end
        @(negedge clk);
        drive(1'b0, 1'b0, '0);
        expect_all_idle("R6");
        repeat (N) @(negedge clk);
        expect_all_idle("R6");
    endtask

    // R1: reset mid-stream clears commands in flight
    task automatic test_midstream_reset;
        @(negedge clk);
        drive(1'b1, 1'b1, 8'hC3);
        @(negedge clk);
        drive(1'b1, 1'b0, 8'h11);
        @(negedge clk);
        drive(1'b0, 1'b0, '0);
        rst_n = 1'b0;
        #1;
        expect_all_idle("R1");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            expect_all_idle("R1");
        end
    endtask

    initial begin
        test_reset();
        test_single_flush();
        test_flush_then_dispatch();
        test_burst();
        test_idle_noise();
        test_midstream_reset();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule